// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the master side of a serial peripheral link. A host writes words into a transmit queue through a small register port. The engine takes one word at a time and shifts it out on MOSI. At the same time it gathers the bits coming back on MISO into a receive queue, where the host reads them through a data port. The word length can be set from 4 to 16 bits, or to 32 bits. SCK polarity and phase, bit order and an internal loopback are all selectable. An optional idle gap can be placed between consecutive words.

The SCK half-period is paced by a clock-enable pulse from a separate prescaler. Each pulse is one half period. The host programs the serial format only while the core is disabled. The host sees queue state and two sticky error flags in an event word, and a mask word turns any of these into an interrupt level. A slave-select word drives the active-low select lines directly.

Top module: `spim_core`

## Requirements
- R1: After reset the mode word reads 0, the event word reads 0x100 (only transmit space set), SCK is low, irq is low and every slave-select line is high.
- R2: The mode word holds: loopback bit 30, SCK idle level bit 29, phase bit 28, MSB-first bit 26, master bit 25, enable bit 24, length code bits 23:20 and gap count bits 11:7. While enable reads 1, a write changes only the enable bit.
- R3: A length code k from 3 to 15 gives words of k+1 bits. Code 0 gives 32-bit words. Each word produces exactly 2×bits SCK edges.
- R4: With bit 26 set, the first bit sent is bit 31 of the written word and the following bits go downward. With bit 26 clear, the first bit sent is bit 0 and the following bits go upward.
- R5: For words shorter than 32 bits, the received value is placed as follows. MSB-first puts its least significant bit at bit 16. LSB-first puts the last received bit at bit 15. Other bits are zero. For 32-bit words, MSB-first puts the first bit at bit 31 and LSB-first puts it at bit 0.
- R6: SCK rests at the level in bit 29 and toggles only on a prescaler pulse. With phase 0, MISO is sampled on the edge that leaves the rest level. With phase 1, it is sampled on the edge that returns to it.
- R7: With gap count g and the next word already queued, the last edge of one word and the first edge of the next are 2g+1 prescaler pulses apart.
- R8: With bit 30 set, the received bits are the transmitted bits and the MISO pin has no effect.
- R9: A write to the transmit port (address 4) queues the word, or drops it when the queue is full. Event bit 8 is 1 while the queue has space. Words leave the queue only while bits 24 and 25 are both 1.
- R10: A read of the receive port (address 5) pops one word. Event bit 9 is 1 while words are waiting. A read from an empty queue returns 0 and sets sticky event bit 11.
- R11: A word that completes while the receive queue is full is dropped and sets sticky event bit 12. Writing 1 to bit 11 or bit 12 of the event word (address 2) clears that bit.
- R12: The capability word (address 0) reads the select-line count in bits 31:24, 1 in bit 16 and the queue depth in bits 15:8.
- R13: The select word (address 6) drives the select lines directly. It resets to all ones. Selecting slave n means clearing bit n-1.
- R14: irq is high exactly when some event bit and the same bit of the mask word (address 3) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_tick | input | 1 | Prescaler pulse, one per SCK half period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Masked event level |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | SS_W | Active-low slave selects |

## Verification
Two things can fall in the same clock: a word completing into a full receive queue and a host access to the event word. The first sets the overrun flag and the second may clear it. A second collision is a transmit write landing on the cycle the engine pops the queue. The bench provokes these by leaving four words unread while a fifth is shifted. It then judges the flag, the irq level and the order of the surviving words against its own queue model. The same model tracks the select lines and is compared on every clock. Serial order and gap spacing are measured from captured edge times.

// File: rtl/spim_pkg.sv
// Package: shared types, register offsets, event bit positions and
// helpers for the SPI master. Assumes a fixed 32-bit data word.
package spim_pkg;

    localparam int WORD_W = 32;

    // Event bit positions (host-visible)
    localparam int EV_TXSPACE = 8;
    localparam int EV_RXDATA  = 9;
    localparam int EV_UNDER   = 11;
    localparam int EV_OVER    = 12;
    localparam logic [31:0] EV_ALL = 32'h0000_1B00;

    typedef enum logic [2:0] {
        A_CAP   = 3'd0,
        A_MODE  = 3'd1,
        A_EVENT = 3'd2,
        A_MASK  = 3'd3,
        A_TXD   = 3'd4,
        A_RXD   = 3'd5,
        A_SSEL  = 3'd6
    } spim_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } spim_state_e;

    typedef struct packed {
        logic       loop;
        logic       cpol;
        logic       cpha;
        logic       msb_first;
        logic       master;
        logic       enable;
        logic [3:0] len_code;
        logic [4:0] gap;
    } spim_mode_t;

    // Number of bits in a word for a given length code (0 selects 32)
    function automatic logic [5:0] word_bits(input logic [3:0] code);
        return (code == 4'd0) ? 6'd32 : ({2'b00, code} + 6'd1);
    endfunction

    // Place mode fields at their host-visible bit positions
    function automatic logic [31:0] mode_pack(input spim_mode_t m);
        logic [31:0] w;
        w        = '0;
        w[30]    = m.loop;
        w[29]    = m.cpol;
        w[28]    = m.cpha;
        w[26]    = m.msb_first;
        w[25]    = m.master;
        w[24]    = m.enable;
        w[23:20] = m.len_code;
        w[11:7]  = m.gap;
        return w;
    endfunction

    // Extract mode fields from a host write
    function automatic spim_mode_t mode_unpack(input logic [31:0] w);
        spim_mode_t m;
        m.loop      = w[30];
        m.cpol      = w[29];
        m.cpha      = w[28];
        m.msb_first = w[26];
        m.master    = w[25];
        m.enable    = w[24];
        m.len_code  = w[23:20];
        m.gap       = w[11:7];
        return m;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
// Module: synchronous single-clock queue. Assumes DEPTH is a power of
// two. A push into a full queue and a pop from an empty queue are ignored.
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    // Qualify requests against occupancy
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
        full    = (count == DEPTH_C);
        empty   = (count == '0);
        rdata   = mem[rptr];
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9: an accepted push alone raises occupancy by one
    p_fifo_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !(pop && !empty)) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/spim_shifter.sv
// Module: serial engine. Loads one word from the transmit queue and
// produces 2*bits SCK edges, one per prescaler pulse. It shifts MOSI and
// samples MISO (or MOSI in loopback) on the phase-selected edges, then
// emits one aligned received word. Assumes the mode is stable while enabled.
module spim_shifter
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  spim_mode_t        mode,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              done_word,
    output logic [WORD_W-1:0] rx_word
);
    spim_state_e       state;
    logic [WORD_W-1:0] sh, rsh, rsh_next, done_raw;
    logic [6:0]        edge_cnt;
    logic [5:0]        gap_cnt;
    logic              sck_q;
    logic [5:0]        nb;
    logic              go, last_edge, leading, in_shift;
    logic              sample_now, shift_now, miso_eff;

    // Edge decode, sampling and shifting decisions
    always_comb begin
        nb         = word_bits(mode.len_code);
        go         = mode.enable && mode.master;
        in_shift   = (state == ST_SHIFT);
        last_edge  = (edge_cnt == ({nb, 1'b0} - 7'd1));
        leading    = ~edge_cnt[0];
        mosi       = mode.msb_first ? sh[WORD_W-1] : sh[0];
        miso_eff   = mode.loop ? mosi : miso;
        sample_now = in_shift && tick && (leading ^ mode.cpha);
        shift_now  = in_shift && tick &&
                     (mode.cpha ? (leading && edge_cnt != 7'd0)
                                : (!leading && !last_edge));
        rsh_next   = mode.msb_first ? {rsh[WORD_W-2:0], miso_eff}
                                    : {miso_eff, rsh[WORD_W-1:1]};
        done_word  = in_shift && tick && last_edge && go;
        done_raw   = sample_now ? rsh_next : rsh;
        tx_pop     = (state == ST_IDLE) && go && tx_valid;
        sck        = sck_q;
    end

    // Align the finished word inside the 32-bit receive register
    always_comb begin
        if (nb == 6'd32)         rx_word = done_raw;
        else if (mode.msb_first) rx_word = done_raw << 16;
        else                     rx_word = done_raw >> 16;
    end

    // Word sequencing: idle, shift, inter-word gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh       <= '0;
            rsh      <= '0;
            edge_cnt <= '0;
            gap_cnt  <= '0;
            sck_q    <= 1'b0;
        end else if (!go) begin
            state <= ST_IDLE;
            sck_q <= mode.cpol;
        end else begin
            case (state)
                ST_IDLE: begin
                    sck_q <= mode.cpol;
                    if (tx_valid) begin
                        sh       <= tx_word;
                        rsh      <= '0;
                        edge_cnt <= '0;
                        state    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sck_q    <= ~sck_q;
                        edge_cnt <= edge_cnt + 7'd1;
                        if (sample_now) rsh <= rsh_next;
                        if (shift_now)
                            sh <= mode.msb_first ? (sh << 1) : (sh >> 1);
                        if (last_edge) begin
                            gap_cnt <= '0;
                            state   <= (mode.gap == 5'd0) ? ST_IDLE : ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_cnt == ({1'b0, mode.gap} << 1) - 6'd1)
                            state <= ST_IDLE;
                        else
                            gap_cnt <= gap_cnt + 6'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a settled idle engine holds SCK at the programmed rest level
    p_sck_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state == ST_IDLE) && $stable(mode.cpol))
        |-> (sck_q == mode.cpol));

    // R3: edge count never exceeds twice the word length
    p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (edge_cnt < {nb, 1'b0}));

    // R7: SCK stays at rest throughout the gap
    p_gap_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (sck_q == mode.cpol));

endmodule

// File: rtl/spim_regs.sv
// Module: host register file. Holds mode, mask, sticky error flags and
// the slave-select word. Decodes queue push/pop and builds the read mux.
// Assumes single-cycle strobes; read data is combinational from bus_addr.
module spim_regs
    import spim_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output spim_mode_t        mode,
    output logic [SS_W-1:0]   ss_n,
    output logic              tx_push,
    input  logic              tx_full,
    output logic              rx_pop,
    input  logic              rx_empty,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              word_lost
);
    spim_mode_t      mode_q;
    logic [31:0]     mask_q, ev_word, cap_word;
    logic            under_q, over_q;
    logic [SS_W-1:0] ss_q;
    logic            wr_mode, wr_event, wr_mask, wr_ssel, rd_rx, under_set;

    // Strobe decode
    always_comb begin
        wr_mode   = bus_wr && (bus_addr == A_MODE);
        wr_event  = bus_wr && (bus_addr == A_EVENT);
        wr_mask   = bus_wr && (bus_addr == A_MASK);
        wr_ssel   = bus_wr && (bus_addr == A_SSEL);
        tx_push   = bus_wr && (bus_addr == A_TXD);
        rd_rx     = bus_rd && (bus_addr == A_RXD);
        rx_pop    = rd_rx && !rx_empty;
        under_set = rd_rx && rx_empty;
    end

    // Event word, capability word and masked interrupt
    always_comb begin
        ev_word             = '0;
        ev_word[EV_TXSPACE] = !tx_full;
        ev_word[EV_RXDATA]  = !rx_empty;
        ev_word[EV_UNDER]   = under_q;
        ev_word[EV_OVER]    = over_q;
        cap_word            = {8'(SS_W), 7'd0, 1'b1, 8'(DEPTH), 8'd0};
        irq                 = |(ev_word & mask_q);
        mode                = mode_q;
        ss_n                = ss_q;
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            A_CAP:   bus_rdata = cap_word;
            A_MODE:  bus_rdata = mode_pack(mode_q);
            A_EVENT: bus_rdata = ev_word;
            A_MASK:  bus_rdata = mask_q;
            A_RXD:   bus_rdata = rx_empty ? '0 : rx_data;
            A_SSEL:  bus_rdata = {{(32-SS_W){1'b1}}, ss_q};
            default: bus_rdata = '0;
        endcase
    end

    // Mode register: only the enable bit is writable while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            if (mode_q.enable) mode_q.enable <= bus_wdata[24];
            else               mode_q        <= mode_unpack(bus_wdata);
        end
    end

    // Mask and slave-select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ss_q   <= '1;
        end else begin
            if (wr_mask) mask_q <= bus_wdata & EV_ALL;
            if (wr_ssel) ss_q   <= bus_wdata[SS_W-1:0];
        end
    end

    // Sticky error flags: setting wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            under_q <= 1'b0;
            over_q  <= 1'b0;
        end else begin
            if (under_set)                           under_q <= 1'b1;
            else if (wr_event && bus_wdata[EV_UNDER]) under_q <= 1'b0;
            if (word_lost)                           over_q  <= 1'b1;
            else if (wr_event && bus_wdata[EV_OVER])  over_q  <= 1'b0;
        end
    end

    // R2: format fields never move while the core was enabled
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_q.enable) |->
        ((mode_pack(mode_q) & ~32'h0100_0000) ==
         ($past(mode_pack(mode_q)) & ~32'h0100_0000)));

    // R13: all selects deasserted right after reset
    p_ss_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ss_q == '1));

    // R10: reading an empty receive port raises the underrun flag
    p_under_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RXD && rx_empty) |=> under_q);

    // R11: a word lost to a full receive queue raises the overrun flag
    p_over_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        word_lost |=> over_q);

endmodule

// File: rtl/spim_core.sv
// Module: top of the SPI master. Joins the register file, the two word
// queues and the serial engine. Assumes sck_tick is a one-cycle pulse
// from an external prescaler; every pulse is one SCK half period.
module spim_core
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SS_W       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_tick,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [2:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq,
    output logic            spi_sck,
    output logic            spi_mosi,
    input  logic            spi_miso,
    output logic [SS_W-1:0] spi_ss_n
);
    spim_mode_t        mode;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] tx_word, rx_word, rx_data;
    logic              done_word, word_lost;

    // Route finished words to the receive queue or the overrun flag
    always_comb begin
        rx_push   = done_word && !rx_full;
        word_lost = done_word && rx_full;
    end

    spim_regs #(.DEPTH(FIFO_DEPTH), .SS_W(SS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .mode(mode), .ss_n(spi_ss_n),
        .tx_push(tx_push), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_empty(rx_empty), .rx_data(rx_data),
        .word_lost(word_lost)
    );

    spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(bus_wdata),
        .pop(tx_pop), .rdata(tx_word),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data),
        .full(rx_full), .empty(rx_empty)
    );

    spim_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tick(sck_tick), .mode(mode),
        .tx_valid(!tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .done_word(done_word), .rx_word(rx_word)
    );

    // R9: no word leaves the transmit queue unless enable and master are set
    p_pop_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (mode.enable && mode.master && !tx_empty));

endmodule

// File: tb/test_spim_core.sv
module test_spim_core;
    localparam logic [2:0] AD_CAP = 3'd0, AD_MODE = 3'd1, AD_EV = 3'd2,
                           AD_MASK = 3'd3, AD_TX = 3'd4, AD_RX = 3'd5,
                           AD_SS = 3'd6;
    localparam logic [31:0] EN = 32'h0100_0000;

    logic        clk = 0, rst_n = 0, sck_tick = 0;
    logic        bus_wr = 0, bus_rd = 0, spi_miso = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        irq, spi_sck, spi_mosi;
    logic [3:0]  spi_ss_n;

    int compared = 0, mismatched = 0, clk_cnt = 0;
    bit cpol_m = 0, cpha_m = 0;
    logic prev_sck = 0, prev_mosi = 0;
    logic [3:0] ss_exp = 4'hF;
    bit got_bits[$];
    int edge_clk[$];
    logic [31:0] rx_q[$];

    spim_core i_spim_core (
        .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ss_n(spi_ss_n)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin @(posedge clk); #1 sck_tick = ~sck_tick; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock model comparison and edge monitor
    always @(negedge clk) begin
        clk_cnt++;
        if (rst_n) chk("R13 select lines", {28'd0, spi_ss_n}, {28'd0, ss_exp});
        if (spi_sck !== prev_sck) begin
            edge_clk.push_back(clk_cnt);
            if ((prev_sck == cpol_m) ^ cpha_m) got_bits.push_back(prev_mosi);
        end
        prev_sck  = spi_sck;
        prev_mosi = spi_mosi;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1 bus_rd = 1; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic sel(input logic [31:0] v);
        @(posedge clk); #1 bus_wr = 1; bus_addr = AD_SS; bus_wdata = v;
        @(posedge clk); ss_exp = v[3:0]; #1 bus_wr = 0;
    endtask

    function automatic logic [31:0] mk(bit lp, bit cp, bit ph, bit mf, bit ms,
                                       logic [3:0] code, logic [4:0] gap);
        logic [31:0] w = '0;
        w[30] = lp; w[29] = cp; w[28] = ph; w[26] = mf; w[25] = ms;
        w[23:20] = code; w[11:7] = gap;
        return w;
    endfunction

    function automatic logic [31:0] bmask(int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    // Expected receive register content from the alignment rules
    function automatic logic [31:0] exp_rx(logic [31:0] w, int n, bit mf, bit lp, bit mv);
        logic [31:0] p;
        if (lp) p = mf ? ((n == 32) ? w : (w >> (32 - n))) : (w & bmask(n));
        else    p = mv ? bmask(n) : 32'h0;
        if (n == 32) return p;
        return mf ? (p << 16) : (p << (16 - n));
    endfunction

    task automatic configure(input logic [31:0] cfg);
        wr(AD_MODE, cfg);
        cpol_m = cfg[29]; cpha_m = cfg[28];
        repeat (4) @(posedge clk);
        got_bits.delete(); edge_clk.delete();
    endtask

    task automatic xfer(input string tag, input bit lp, cp, ph, mf,
                        input logic [3:0] code, input logic [31:0] w, input bit mv);
        logic [31:0] cfg, g, e, r;
        int n;
        n = (code == 0) ? 32 : int'(code) + 1;
        cfg = mk(lp, cp, ph, mf, 1'b1, code, 5'd0);
        spi_miso = mv;
        configure(cfg);
        wr(AD_TX, w);
        wr(AD_MODE, cfg | EN);
        repeat (4 * n + 30) @(posedge clk);
        chk({tag, " R3 edge count"}, edge_clk.size(), 2 * n);
        g = '0; e = '0;
        for (int i = 0; i < n && i < got_bits.size(); i++) g[i] = got_bits[i];
        for (int i = 0; i < n; i++) e[i] = mf ? w[31 - i] : w[i];
        chk({tag, " R4 serial order"}, g, e);
        rd(AD_RX, r);
        chk({tag, " R5 receive alignment"}, r, exp_rx(w, n, mf, lp, mv));
        wr(AD_MODE, cfg);
    endtask

    initial begin
        logic [31:0] r, cfg;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        repeat (2) @(posedge clk);

        // R1 / R12 reset state and capability
        rd(AD_MODE, r);  chk("R1 mode reset", r, 32'h0);
        rd(AD_EV, r);    chk("R1 event reset", r, 32'h100);
        rd(AD_CAP, r);   chk("R12 capability", r, 32'h0401_0400);
        @(negedge clk);
        chk("R1 sck/irq reset", {30'd0, spi_sck, irq}, 32'h0);

        // Formats: R3 R4 R5 R6 R8
        xfer("R8 loop msb8 mode0", 1, 0, 0, 1, 4'd7, 32'hA5C3_0000, 0);
        xfer("R6 loop lsb12 mode3", 1, 1, 1, 0, 4'd11, 32'h0000_0ABC, 0);
        xfer("R3 loop msb32 mode1", 1, 0, 1, 1, 4'd0, 32'h1234_5678, 0);
        xfer("R3 loop lsb32 mode2", 1, 1, 0, 0, 4'd0, 32'h89AB_CDEF, 1);
        xfer("R8 pin msb4", 0, 0, 0, 1, 4'd3, 32'h5000_0000, 1);
        xfer("R8 pin lsb16", 0, 1, 1, 0, 4'd15, 32'h0000_1234, 0);

        // R2: format frozen while enabled
        cfg = mk(1, 0, 0, 1, 1, 4'd7, 5'd2);
        configure(cfg);
        wr(AD_MODE, cfg | EN);
        wr(AD_MODE, mk(0, 1, 1, 0, 1, 4'd3, 5'd9) | EN);
        rd(AD_MODE, r);  chk("R2 write ignored while enabled", r, cfg | EN);
        wr(AD_MODE, 32'h0);
        rd(AD_MODE, r);  chk("R2 only enable clears", r, cfg);

        // R7: gap spacing, g=3 then g=0
        for (int k = 0; k < 2; k++) begin
            int g = (k == 0) ? 3 : 0;
            cfg = mk(1, 0, 0, 1, 1, 4'd3, 5'(g));
            configure(cfg);
            wr(AD_TX, 32'h9000_0000); wr(AD_TX, 32'h6000_0000);
            wr(AD_MODE, cfg | EN);
            repeat (120) @(posedge clk);
            chk("R7 edges for two words", edge_clk.size(), 16);
            if (edge_clk.size() >= 9)
                chk("R7 inter-word spacing", edge_clk[8] - edge_clk[7], 2 * (2 * g + 1));
            rd(AD_RX, r); chk("R7 first word", r, 32'h0009_0000);
            rd(AD_RX, r); chk("R7 second word", r, 32'h0006_0000);
            wr(AD_MODE, cfg);
        end

        // R9: gating by master bit
        cfg = mk(1, 0, 0, 1, 0, 4'd7, 5'd0);
        configure(cfg);
        wr(AD_TX, 32'h3C00_0000);
        wr(AD_MODE, cfg | EN);
        repeat (100) @(posedge clk);
        chk("R9 no edges without master", edge_clk.size(), 0);
        rd(AD_EV, r);  chk("R9 word held", r, 32'h100);
        cfg[25] = 1'b1;
        wr(AD_MODE, 32'h0); wr(AD_MODE, cfg); wr(AD_MODE, cfg | EN);
        repeat (80) @(posedge clk);
        rd(AD_RX, r);  chk("R9 held word sent once enabled", r, 32'h003C_0000);
        wr(AD_MODE, cfg);

        // R9 R10 R11 R14: full queues, overrun, underrun
        configure(cfg);
        rx_q.delete();
        for (int i = 0; i < 5; i++) wr(AD_TX, 32'(i + 1) << 24);
        for (int i = 0; i < 4; i++) rx_q.push_back(32'(i + 1) << 16);
        rd(AD_EV, r);  chk("R9 full queue no space", r, 32'h000);
        wr(AD_MODE, cfg | EN);
        repeat (400) @(posedge clk);
        rd(AD_EV, r);  chk("R10 data waiting", r, 32'h300);
        wr(AD_TX, 32'h7700_0000);
        repeat (100) @(posedge clk);
        rd(AD_EV, r);  chk("R11 overrun flagged", r, 32'h1300);
        wr(AD_MASK, 32'h1000);
        @(negedge clk); chk("R14 irq on masked overrun", {31'd0, irq}, 32'h1);
        for (int i = 0; i < 4; i++) begin
            rd(AD_RX, r); chk("R11 survivors in order", r, rx_q.pop_front());
        end
        rd(AD_RX, r);  chk("R10 empty read returns 0", r, 32'h0);
        rd(AD_EV, r);  chk("R10 underrun flagged", r, 32'h1900);
        wr(AD_EV, 32'h1800);
        rd(AD_EV, r);  chk("R11 write one clears", r, 32'h100);
        @(negedge clk); chk("R14 irq drops after clear", {31'd0, irq}, 32'h0);
        wr(AD_MASK, 32'h100);
        @(negedge clk); chk("R14 irq on tx space", {31'd0, irq}, 32'h1);
        wr(AD_MASK, 32'h0);
        wr(AD_MODE, cfg);

        // R13 slave select
        sel(~(32'h1 << 2));
        rd(AD_SS, r);  chk("R13 select readback", r, 32'hFFFF_FFFB);
        sel(32'hFFFF_FFFF);
        repeat (4) @(posedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule